// File: doc/BRIEF.md
# Serial In-System Programming Target for a Code Array

This block is the target-side end of a three-wire serial programming link for an on-chip code store. While the programming-mode input is held high, it samples a serial clock and a serial data input in the system clock domain. It assembles 4-byte instructions from those samples and drives a serial data output in return. The code store is modelled as a small byte array inside the block.

A host must first send the enable instruction. Only then will the block accept erase, byte-write and byte-read instructions. Writes behave like flash cells: they can only clear bits, so a location must be erased before it can take a value with more ones. Every write or erase starts a self-timed busy window, and any write or erase that arrives during that window is dropped. A read of the location just written, made inside the window, returns the byte with its top bit inverted. The host can poll on this to find out when the write has finished.

Top module: `isp_prog_slave`

## Requirements
- R1: While `prog_mode` is low, `miso` is driven 0 from the next clock, the enable state is cleared, serial clock edges are ignored, and any partly received instruction is discarded.
- R2: Until an instruction with first byte 0xAC and second byte 0x53 has been received, reads return 0x00 and writes and erases leave the array unchanged.
- R3: Every instruction is exactly 32 bits, sent MSB first. `mosi` is sampled on the rising edge of `sck`. `miso` changes only after a falling edge of `sck`. During the first two bytes of an instruction, `miso` is 0.
- R4: In the third byte of any instruction whose first byte is 0xAC, `miso` returns the second byte received. For the enable instruction this byte is 0x53.
- R5: Instruction 0xAC 0x80 x x, when enabled and not busy, sets every array location to 0xFF and starts the busy window.
- R6: Instruction 0x40 Ahi Alo D, when enabled and not busy, stores the old byte AND D at address Alo, using its low `ADDR_W` bits so that higher address bits wrap. It then starts a busy window of `BUSY_CYCLES` clocks.
- R7: Instruction 0x20 Ahi Alo x, when enabled, returns the stored byte at the addressed location on `miso`, MSB first, during the fourth byte.
- R8: During the busy window that follows a write, a read of that same address returns the stored byte with bit 7 inverted. A read of any other address returns the stored byte unchanged.
- R9: A write or an erase received while the busy window is open is ignored.
- R10: `sck` and `mosi` each pass through `SYNC_STAGES` flip-flops before edge detection. A rising and a falling edge are never seen in the same clock. Correct operation requires each `sck` phase to last at least 8 system clocks.
- R11: After `rst_n` is released, every array byte is 0xFF, the block is not enabled and not busy, and `miso` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| prog_mode | input | 1 | High to select serial programming mode |
| sck | input | 1 | Serial shift clock from the host, asynchronous |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
A `sck` edge reaches the core `SYNC_STAGES` clocks after the pin moves. The instruction-complete pulse follows the last rising edge by one more clock. An array update or the start of the busy window lands one clock after that, and `miso` is updated one clock after a synchronised falling edge. The bench holds each `sck` phase for 10 system clocks. It samples `miso` at the end of the low phase, well after the shift-out has settled, and it waits past `BUSY_CYCLES` before any check that needs the busy window closed. The polling and dropped-write checks are placed inside the busy window: the next instruction ends about 660 clocks after the write, well inside a 2000-clock window.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [7:0] OP_ENABLE = 8'hAC;
  localparam logic [7:0] SUB_ENABLE = 8'h53;
  localparam logic [7:0] SUB_ERASE = 8'h80;
  localparam logic [7:0] OP_WRITE = 8'h40;
  localparam logic [7:0] OP_READ = 8'h20;
  localparam logic [7:0] ERASED = 8'hFF;

  // flash cells only clear bits on programming
  function automatic logic [7:0] flash_prog(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // polling response: top bit flipped while the write is in progress
  function automatic logic [7:0] poll_byte(input logic [7:0] b, input logic polling);
    return b ^ {polling, 7'b0};
  endfunction
endpackage

// File: rtl/isp_sck_sync.sv
module isp_sck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  logic [STAGES-1:0] sck_q;
  logic [STAGES-1:0] mosi_q;
  logic              sck_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_q[i]  <= 1'b0;
          mosi_q[i] <= 1'b0;
        end else if (i == 0) begin
          sck_q[i]  <= sck;
          mosi_q[i] <= mosi;
        end else begin
          sck_q[i]  <= sck_q[(i == 0) ? 0 : i-1];
          mosi_q[i] <= mosi_q[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_q[STAGES-1];
  end

  assign sck_rise = sck_q[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_q[STAGES-1] & sck_d;
  assign mosi_s   = mosi_q[STAGES-1];
endmodule

// File: rtl/isp_frame.sv
module isp_frame #(
  parameter int WORD_BITS = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         prog_mode,
  input  logic                         sck_rise,
  input  logic                         sck_fall,
  input  logic                         mosi_s,
  input  logic [7:0]                   load_byte,
  output logic [WORD_BITS-1:0]         rx_word,
  output logic [$clog2(WORD_BITS)-1:0] bit_cnt,
  output logic                         cmd_done,
  output logic                         miso
);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic [7:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word  <= '0;
      bit_cnt  <= '0;
      cmd_done <= 1'b0;
      tx_sr    <= '0;
    end else if (!prog_mode) begin
      bit_cnt  <= '0;
      cmd_done <= 1'b0;
      tx_sr    <= '0;
    end else begin
      cmd_done <= sck_rise && (bit_cnt == LAST);
      if (sck_rise) begin
        rx_word <= {rx_word[WORD_BITS-2:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (sck_fall) begin
        if (bit_cnt[2:0] == 3'd0) tx_sr <= load_byte;
        else                      tx_sr <= {tx_sr[6:0], 1'b0};
      end
    end
  end

  assign miso = tx_sr[7];
endmodule

// File: rtl/isp_array.sv
module isp_array
  import isp_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              er_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              poll_hit
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [7:0]        mem [DEPTH];
  logic [CNT_W-1:0]  busy_cnt;
  logic [ADDR_W-1:0] last_addr;
  logic              last_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (er_fire) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (wr_fire) begin
      mem[wr_addr] <= flash_prog(mem[wr_addr], wr_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt   <= '0;
      last_addr  <= '0;
      last_valid <= 1'b0;
    end else begin
      if (wr_fire || er_fire)  busy_cnt <= CNT_W'(BUSY_CYCLES);
      else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (wr_fire) begin
        last_addr  <= wr_addr;
        last_valid <= 1'b1;
      end else if (er_fire) begin
        last_valid <= 1'b0;
      end
    end
  end

  assign busy     = (busy_cnt != '0);
  assign poll_hit = busy && last_valid && (rd_addr == last_addr);
  assign rd_data  = poll_byte(mem[rd_addr], poll_hit);
endmodule

// File: rtl/isp_prog_slave.sv
module isp_prog_slave
  import isp_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BUSY_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_mode,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int WORD_BITS = 32;
  localparam int CNT_W     = $clog2(WORD_BITS);

  logic                 sck_rise, sck_fall, mosi_s;
  logic [WORD_BITS-1:0] rx_word;
  logic [CNT_W-1:0]     bit_cnt;
  logic                 cmd_done;
  logic [7:0]           load_byte;
  logic [7:0]           rd_data;
  logic                 busy, poll_hit;
  logic                 en;
  logic                 en_fire, er_fire, wr_fire;

  logic [7:0] c_op, c_sub, c_lo, c_dat;
  assign c_op  = rx_word[31:24];
  assign c_sub = rx_word[23:16];
  assign c_lo  = rx_word[15:8];
  assign c_dat = rx_word[7:0];

  isp_sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
  );

  isp_frame #(.WORD_BITS(WORD_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
    .load_byte(load_byte), .rx_word(rx_word), .bit_cnt(bit_cnt),
    .cmd_done(cmd_done), .miso(miso)
  );

  // instruction decode, valid in the cycle of cmd_done
  assign en_fire = cmd_done && (c_op == OP_ENABLE) && (c_sub == SUB_ENABLE);
  assign er_fire = cmd_done && en && !busy && (c_op == OP_ENABLE) && (c_sub == SUB_ERASE);
  assign wr_fire = cmd_done && en && !busy && (c_op == OP_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en <= 1'b0;
    else if (!prog_mode) en <= 1'b0;
    else if (en_fire)    en <= 1'b1;
  end

  isp_array #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .er_fire(er_fire),
    .wr_addr(c_lo[ADDR_W-1:0]), .wr_data(c_dat),
    .rd_addr(rx_word[ADDR_W-1:0]), .rd_data(rd_data),
    .busy(busy), .poll_hit(poll_hit)
  );

  // response byte selected at each byte boundary of the shift-out
  always_comb begin
    load_byte = 8'h00;
    case (bit_cnt[4:3])
      2'd2: if (rx_word[15:8] == OP_ENABLE) load_byte = rx_word[7:0];
      2'd3: if (en && rx_word[23:16] == OP_READ) load_byte = rd_data;
      default: load_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/isp_prog_slave_chk.sv
module isp_prog_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic prog_mode,
  input logic miso,
  input logic sck_rise,
  input logic sck_fall,
  input logic cmd_done,
  input logic en,
  input logic busy,
  input logic en_fire,
  input logic er_fire,
  input logic wr_fire
);
  p_idle_miso_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |=> !miso);

  p_en_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |=> !en);

  p_en_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> $past(cmd_done));

  p_miso_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && $past(prog_mode) && miso != $past(miso)) |-> $past(sck_fall));

  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire || er_fire) |=> busy);

  p_busy_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_done));

  p_fire_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_fire, er_fire, en_fire}));

  p_edge_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_rise && sck_fall));
endmodule

bind isp_prog_slave isp_prog_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .miso(miso),
  .sck_rise(sck_rise), .sck_fall(sck_fall), .cmd_done(cmd_done),
  .en(en), .busy(busy), .en_fire(en_fire), .er_fire(er_fire), .wr_fire(wr_fire)
);

// File: tb/isp_prog_slave_test.sv
module isp_prog_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;
  localparam int SETTLE     = 2100;
  localparam int NVEC       = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_mode = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isp_prog_slave uut (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  // [63:32] instruction, [31:24] third-byte reply, [23:16] fourth-byte reply, [15:0] wait
  localparam logic [63:0] VEC [NVEC] = '{
    {32'hAC530000, 8'h53, 8'h00, 16'd0},     // R4 enable echo
    {32'hAC800000, 8'h80, 8'h00, 16'd2100},  // R5 erase
    {32'h400005A5, 8'h00, 8'h00, 16'd0},     // R6 write
    {32'h20000500, 8'h00, 8'h25, 16'd2100},  // R8 polling, bit 7 flipped
    {32'h20000500, 8'h00, 8'hA5, 16'd0},     // R7 settled read
    {32'h4000063C, 8'h00, 8'h00, 16'd2100},
    {32'h400006F0, 8'h00, 8'h00, 16'd2100},  // R6 AND with old contents
    {32'h20000600, 8'h00, 8'h30, 16'd0},
    {32'h20001000, 8'h00, 8'hFF, 16'd0},     // R5 untouched location erased
    {32'h40000711, 8'h00, 8'h00, 16'd0},
    {32'h40000822, 8'h00, 8'h00, 16'd2100},  // R9 write while busy dropped
    {32'h20000700, 8'h00, 8'h11, 16'd0},
    {32'h20000800, 8'h00, 8'hFF, 16'd0},     // R9
    {32'h40000900, 8'h00, 8'h00, 16'd0},
    {32'hAC800000, 8'h80, 8'h00, 16'd2100},  // R9 erase while busy dropped
    {32'h20000900, 8'h00, 8'h00, 16'd0},
    {32'hAC800000, 8'h80, 8'h00, 16'd2100},  // R5 erase
    {32'h20000500, 8'h00, 8'hFF, 16'd0},
    {32'h20000900, 8'h00, 8'hFF, 16'd0},
    {32'h4001455A, 8'h00, 8'h00, 16'd2100},  // R6 address wraps to 0x05
    {32'h20000500, 8'h00, 8'h5A, 16'd0},
    {32'h40000A66, 8'h00, 8'h00, 16'd0},
    {32'h20000B00, 8'h00, 8'hFF, 16'd0},     // R8 other address, no flip
    {32'h20000A00, 8'h00, 8'hE6, 16'd2100},  // R8 flip on MSB-clear data
    {32'h20000A00, 8'h00, 8'h66, 16'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Send the top nbits of w, MSB first; record miso before each rising edge.
  task automatic xfer(input logic [31:0] w, input int nbits, output logic [31:0] r);
    r = '0;
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      mosi = w[31-k];
      repeat (HALF) @(negedge clk);
      r[31-k] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 miso after reset", {31'b0, miso}, 32'd0);
    prog_mode = 1'b1;
    repeat (5) @(negedge clk);

    // R2: nothing works before enable
    xfer(32'h20000500, 32, r);
    chk("R2 read refused before enable", r, 32'h0);
    xfer(32'h40000500, 32, r);
    xfer(32'hAC530000, 32, r);
    chk("R4 enable echo", {24'b0, r[15:8]}, 32'h53);
    chk("R3 first two bytes silent", {16'b0, r[31:16]}, 32'h0);
    xfer(32'h20000500, 32, r);
    chk("R2 R11 pre-enable write had no effect", {24'b0, r[7:0]}, 32'hFF);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [63:0] e;
      e = VEC[v];
      xfer(e[63:32], 32, r);
      chk((e[63:56] == 8'h20) ? "R7 R10 read reply" : "R3 fourth-byte reply",
          {24'b0, r[7:0]}, {24'b0, e[23:16]});
      chk(e[63:56] == 8'hAC ? "R4 third-byte echo" : "R3 third byte silent",
          {24'b0, r[15:8]}, {24'b0, e[31:24]});
      if (e[15:0] != 16'd0) repeat (int'(e[15:0])) @(negedge clk);
    end
    repeat (SETTLE) @(negedge clk);

    // R1: partial instruction then leave programming mode
    xfer(32'h40000C00, 16, r);
    prog_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 miso low outside mode", {31'b0, miso}, 32'd0);
    xfer(32'hAC530000, 32, r);   // ignored: mode low
    prog_mode = 1'b1;
    repeat (5) @(negedge clk);
    xfer(32'h20000C00, 32, r);
    chk("R1 enable cleared on mode exit", r, 32'h0);
    xfer(32'hAC530000, 32, r);
    chk("R1 R3 framing realigned", {24'b0, r[15:8]}, 32'h53);
    xfer(32'h20000C00, 32, r);
    chk("R1 partial write discarded", {24'b0, r[7:0]}, 32'hFF);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule